// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller sits next to a small processor core and decides which interrupt, if any, the core should take at each instruction boundary. It watches a fixed set of request lines. Each line is built either as an edge-type source, whose events are caught in a sticky flag, or as a level-type source, which requests only while its input is high. Slot 0 of the vector table belongs to reset and is never requested through this block. Of the remaining pending sources that are enabled, the lowest index wins.

When the core reports that an instruction has retired and a request may be served, the controller raises a one-cycle accept strobe. In the same cycle it drives the vector address, which is the table base plus twice the winning index. The table base is either zero or a parameterized boot-section base, picked by a vector-select control bit. Taking an interrupt clears the global enable in hardware. A return-from-interrupt sets it again, and at least one further instruction must then retire before the next acceptance. A disable-interrupt instruction blocks acceptance in its own cycle.

Software reaches the enable mask, the write-one-to-clear flag register and the control bits through a small write port. The current state is visible on output ports.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Among sources that are pending and enabled, the one with the lowest index is taken. Index 0 is never taken, and its request and enable bits are ignored.
- R2: `take_o` is high only in a cycle where `retire_i` is high, the global enable is one, the winning source's enable bit is one, and neither `reti_i` nor `cli_i` is high.
- R3: In the cycle after `take_o` is high, the global enable reads zero.
- R4: The global enable is zero after reset. A `reti_i` pulse sets it. A control write (`cfg_sel_i`=2) loads it from `cfg_wdata_i[0]`. Taking an interrupt or `cli_i` overrides both, then `reti_i` overrides the write. Setting it from a handler lets a newly pending enabled source be taken (nesting).
- R5: An edge-type source's flag is set by a high `src_i` bit even while its enable or the global enable is zero. The flag stays set until it is cleared.
- R6: Taking an edge-type source clears its flag. A flag write (`cfg_sel_i`=1) clears each flag whose `cfg_wdata_i` bit is one and leaves the flags written with zero unchanged. A new event in the same cycle as a clear leaves the flag set.
- R7: Level-type sources (bits set in LEVEL_MASK, default 8'hC0) never show a flag. They request only while `src_i` is high, so a condition that is gone before the source is enabled is never taken.
- R8: After `reti_i`, the first later cycle with `retire_i` (and no `reti_i`) cannot take an interrupt. Acceptance is possible again from the next retirement on.
- R9: In a cycle with `cli_i` high, `take_o` stays low, and the global enable reads zero afterwards.
- R10: `vec_addr_o` equals base + 2 × winning index. The base is 0 when vector select (`cfg_wdata_i[1]` of a control write) is zero, and BOOT_BASE (default 16'h3C00) when it is one.
- R11: An enable-mask write (`cfg_sel_i`=0) loads all enable bits from `cfg_wdata_i`. The enable mask and the vector select are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Event pulses (edge-type) or conditions (level-type) per source |
| retire_i | input | 1 | An instruction retired; the core is at a boundary |
| reti_i | input | 1 | Return-from-interrupt executed |
| cli_i | input | 1 | Disable-interrupt instruction executed |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | 0 enable mask, 1 flag clear, 2 control |
| cfg_wdata_i | input | NUM_SRC | Write data |
| take_o | output | 1 | Accept strobe, one cycle |
| vec_addr_o | output | ADDR_W | Vector address of the winning source |
| gie_o | output | 1 | Global enable |
| vsel_o | output | 1 | Vector table select |
| enable_o | output | NUM_SRC | Per-source enable mask |
| flags_o | output | NUM_SRC | Pending flags of edge-type sources |

## Verification
The bench targets the retirement right after a return. A design without the gap would take there, back to back with the handler it just left. It also drives a disable instruction in the same cycle as a boundary with a pending request, which a registered enable check would accept one cycle too late. Several flags are left pending while the global enable is off, so the bench can confirm that they come out one at a time in index order and that the vector base follows the select bit. A level condition that goes away before it is enabled, and a clear write that coincides with a fresh event, check that the design neither remembers a level request nor loses an edge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_FLAGCLR = 2'd1,
    CFG_CONTROL = 2'd2
  } cfg_sel_e;

  localparam int VEC_ENTRY_SHIFT = 1; // two words per table slot
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               en_we_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic               take_i,
  input  logic [IDX_W-1:0]   take_idx_i,
  output logic [NUM_SRC-1:0] enable_o,
  output logic [NUM_SRC-1:0] flags_o,
  output logic [NUM_SRC-1:0] pending_o
);
  logic [NUM_SRC-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (en_we_i) en_q <= wdata_i;
  end
  assign enable_o = en_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == 0) begin : g_reset_slot
      logic unused_slot0;
      assign unused_slot0 = src_i[0];
      assign flags_o[0]   = 1'b0;
      assign pending_o[0] = 1'b0;
    end else if (LEVEL_MASK[i]) begin : g_level
      assign flags_o[i]   = 1'b0;
      assign pending_o[i] = src_i[i] & en_q[i];
    end else begin : g_edge
      logic flag_q;
      logic clear;
      assign clear = (clr_we_i && wdata_i[i]) ||
                     (take_i && (take_idx_i == IDX_W'(i)));
      always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else if (src_i[i]) flag_q <= 1'b1;
        else if (clear) flag_q <= 1'b0;
      end
      assign flags_o[i]   = flag_q;
      assign pending_o[i] = flag_q & en_q[i];
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic       clk,
  input  logic       rst,
  input  logic       retire_i,
  input  logic       reti_i,
  input  logic       cli_i,
  input  logic       ctl_we_i,
  input  logic [1:0] ctl_wdata_i,
  input  logic       any_req_i,
  output logic       take_o,
  output logic       gie_o,
  output logic       vsel_o
);
  logic gie_q, gap_q, vsel_q;

  assign take_o = retire_i && gie_q && !cli_i && !reti_i && !gap_q && any_req_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q  <= 1'b0;
      gap_q  <= 1'b0;
      vsel_q <= 1'b0;
    end else begin
      if (take_o || cli_i) gie_q <= 1'b0;
      else if (reti_i) gie_q <= 1'b1;
      else if (ctl_we_i) gie_q <= ctl_wdata_i[0];

      if (reti_i) gap_q <= 1'b1;
      else if (retire_i) gap_q <= 1'b0;

      if (ctl_we_i) vsel_q <= ctl_wdata_i[1];
    end
  end

  assign gie_o  = gie_q;
  assign vsel_o = vsel_q;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = 16,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hC0,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'h3C00,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               retire_i,
  input  logic               reti_i,
  input  logic               cli_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [NUM_SRC-1:0] cfg_wdata_i,
  output logic               take_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic               gie_o,
  output logic               vsel_o,
  output logic [NUM_SRC-1:0] enable_o,
  output logic [NUM_SRC-1:0] flags_o
);
  import irq_ctrl_pkg::*;

  logic [NUM_SRC-1:0] pending;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic               en_we, clr_we, ctl_we;
  logic [ADDR_W-1:0]  base;

  assign en_we  = cfg_we_i && (cfg_sel_i == CFG_ENABLE);
  assign clr_we = cfg_we_i && (cfg_sel_i == CFG_FLAGCLR);
  assign ctl_we = cfg_we_i && (cfg_sel_i == CFG_CONTROL);

  irq_flag_bank #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
    .clk(clk), .rst(rst), .src_i(src_i),
    .en_we_i(en_we), .clr_we_i(clr_we), .wdata_i(cfg_wdata_i),
    .take_i(take_o), .take_idx_i(win_idx),
    .enable_o(enable_o), .flags_o(flags_o), .pending_o(pending)
  );

  irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .req_i(pending), .valid_o(win_valid), .idx_o(win_idx)
  );

  irq_gate u_gate (
    .clk(clk), .rst(rst), .retire_i(retire_i), .reti_i(reti_i), .cli_i(cli_i),
    .ctl_we_i(ctl_we), .ctl_wdata_i(cfg_wdata_i[1:0]), .any_req_i(win_valid),
    .take_o(take_o), .gie_o(gie_o), .vsel_o(vsel_o)
  );

  assign base       = vsel_o ? BOOT_BASE : '0;
  assign vec_addr_o = base + (ADDR_W'(win_idx) << VEC_ENTRY_SHIFT);
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_i,
  input logic               retire_i,
  input logic               reti_i,
  input logic               cli_i,
  input logic               cfg_we_i,
  input logic [1:0]         cfg_sel_i,
  input logic [NUM_SRC-1:0] cfg_wdata_i,
  input logic               take_o,
  input logic [ADDR_W-1:0]  vec_addr_o,
  input logic               gie_o,
  input logic [NUM_SRC-1:0] flags_o
);
  // one retirement seen since the last return
  logic ret_since_q;
  always_ff @(posedge clk) begin
    if (rst) ret_since_q <= 1'b1;
    else if (reti_i) ret_since_q <= 1'b0;
    else if (retire_i && !take_o) ret_since_q <= 1'b1;
  end

  a_r3_gie_drops: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !gie_o);
  a_r2_take_gated: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (gie_o && retire_i && !reti_i));
  a_r9_cli_blocks: assert property (@(posedge clk) disable iff (rst)
    cli_i |-> !take_o);
  a_r9_cli_clears: assert property (@(posedge clk) disable iff (rst)
    cli_i |=> !gie_o);
  a_r8_gap: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ret_since_q);
  a_r10_align: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !vec_addr_o[0]);
  a_r4_reti_sets: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !cli_i && !take_o) |=> gie_o);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_w1c
    a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
      (cfg_we_i && cfg_sel_i == 2'd1 && cfg_wdata_i[k] && !src_i[k]) |=> !flags_o[k]);
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
      (flags_o[k] && !take_o && !(cfg_we_i && cfg_sel_i == 2'd1 && cfg_wdata_i[k]))
        |=> flags_o[k]);
  end
endmodule

bind vec_irq_ctrl irq_ctrl_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .retire_i(retire_i), .reti_i(reti_i),
  .cli_i(cli_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
  .cfg_wdata_i(cfg_wdata_i), .take_o(take_o), .vec_addr_o(vec_addr_o),
  .gie_o(gie_o), .flags_o(flags_o)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int AW = 16;
  localparam logic [N-1:0] LVL = 8'hC0;
  localparam logic [AW-1:0] BOOT = 16'h3C00;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] src_i = '0, cfg_wdata_i = '0;
  logic retire_i = 0, reti_i = 0, cli_i = 0, cfg_we_i = 0;
  logic [1:0] cfg_sel_i = '0;
  logic take_o, gie_o, vsel_o;
  logic [AW-1:0] vec_addr_o;
  logic [N-1:0] enable_o, flags_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic m_gie = 0, m_gap = 0, m_vsel = 0;
  logic [N-1:0] m_en = '0, m_flags = '0;
  logic got_take;
  logic [AW-1:0] got_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW), .LEVEL_MASK(LVL), .BOOT_BASE(BOOT)) i_vec_irq_ctrl (
    .clk(clk), .rst(rst), .src_i(src_i), .retire_i(retire_i), .reti_i(reti_i),
    .cli_i(cli_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .take_o(take_o), .vec_addr_o(vec_addr_o),
    .gie_o(gie_o), .vsel_o(vsel_o), .enable_o(enable_o), .flags_o(flags_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int winner(logic [N-1:0] p);
    for (int i = 1; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  // one clock step: drive, compare outputs against the model, advance both
  task automatic step(logic ret, logic rti, logic cl, logic we, logic [1:0] sel,
                      logic [N-1:0] wd, logic [N-1:0] src);
    logic [N-1:0] pend, clr, n_flags;
    logic e_take;
    int w;
    retire_i = ret; reti_i = rti; cli_i = cl; cfg_we_i = we;
    cfg_sel_i = sel; cfg_wdata_i = wd; src_i = src;
    #1;
    pend = ((m_flags & ~LVL) | (src & LVL)) & m_en;
    pend[0] = 1'b0;
    w = winner(pend);
    e_take = ret && m_gie && !cl && !rti && !m_gap && (w > 0);
    got_take = take_o; got_vec = vec_addr_o;
    chk("R2 take", 32'(take_o), 32'(e_take));
    if (e_take) chk("R10 vector", 32'(vec_addr_o), 32'((m_vsel ? BOOT : 16'h0) + 16'(w * 2)));
    clr = (we && sel == 2'd1) ? wd : '0;
    if (e_take && !LVL[w]) clr[w] = 1'b1;
    n_flags = (m_flags & ~clr) | (src & ~LVL);
    n_flags[0] = 1'b0;
    @(posedge clk);
    m_flags = n_flags;
    if (we && sel == 2'd0) m_en = wd;
    if (e_take || cl) m_gie = 0; else if (rti) m_gie = 1; else if (we && sel == 2'd2) m_gie = wd[0];
    if (rti) m_gap = 1; else if (ret) m_gap = 0;
    if (we && sel == 2'd2) m_vsel = wd[1];
    #1;
    chk("R4 gie", 32'(gie_o), 32'(m_gie));
    chk("R5 flags", 32'(flags_o), 32'(m_flags));
    chk("R11 enable", 32'(enable_o), 32'(m_en));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #1;
    chk("R4 reset gie", 32'(gie_o), 0);
    chk("R5 reset flags", 32'(flags_o), 0);
    chk("R11 reset vsel", 32'(vsel_o), 0);
    // R5: event caught while disabled
    step(0,0,0,0,0,0, 8'h08);
    chk("R5 flag set while disabled", 32'(flags_o[3]), 1);
    step(0,0,0,1,2'd0,8'hFF,0);
    step(0,0,0,1,2'd2,8'h01,0);
    step(1,0,0,0,0,0,0);
    chk("R2 take at boundary", 32'(got_take), 1);
    chk("R10 vector of source 3", 32'(got_vec), 32'h6);
    chk("R3 gie cleared by take", 32'(gie_o), 0);
    chk("R6 flag cleared by take", 32'(flags_o[3]), 0);
    // R1 priority, R8 gap after return
    step(0,0,0,0,0,0, 8'h24);
    step(0,0,0,1,2'd2,8'h01,0);
    step(1,0,0,0,0,0,0);
    chk("R1 lowest index first", 32'(got_vec), 32'h4);
    step(0,1,0,0,0,0,0);
    chk("R4 reti sets gie", 32'(gie_o), 1);
    step(1,0,0,0,0,0,0);
    chk("R8 no take right after return", 32'(got_take), 0);
    step(1,0,0,0,0,0,0);
    chk("R8 take after one retirement", 32'(got_take), 1);
    chk("R1 next pending in order", 32'(got_vec), 32'hA);
    // R6 write-one-to-clear
    step(0,0,0,0,0,0, 8'h10);
    step(0,0,0,1,2'd1,8'h00,0);
    chk("R6 zero write keeps flag", 32'(flags_o[4]), 1);
    step(0,0,0,1,2'd1,8'h10,8'h10);
    chk("R6 event beats clear", 32'(flags_o[4]), 1);
    step(0,0,0,1,2'd1,8'h10,0);
    chk("R6 one clears flag", 32'(flags_o[4]), 0);
    // R7 level source 6
    step(0,0,0,1,2'd0,8'h3F,8'h40);
    chk("R7 level leaves no flag", 32'(flags_o), 0);
    step(0,0,0,1,2'd0,8'hFF,0);
    step(0,0,0,1,2'd2,8'h01,0);
    step(1,0,0,0,0,0,0);
    chk("R7 vanished level not taken", 32'(got_take), 0);
    step(1,0,0,0,0,0,8'h40);
    chk("R7 present level taken", 32'(got_vec), 32'hC);
    chk("R7 level still no flag", 32'(flags_o[6]), 0);
    // R9 disable in same cycle
    step(0,0,0,0,0,0, 8'h02);
    step(0,0,0,1,2'd2,8'h01,0);
    step(1,0,1,0,0,0,0);
    chk("R9 cli blocks take", 32'(got_take), 0);
    chk("R9 cli clears gie", 32'(gie_o), 0);
    // R10 relocated table
    step(0,0,0,1,2'd2,8'h03,0);
    step(1,0,0,0,0,0,0);
    chk("R10 boot base vector", 32'(got_vec), 32'h3C02);
    // R4 nesting: handler re-enables, new source preempts
    step(0,0,0,0,0,0, 8'h20);
    step(0,0,0,1,2'd2,8'h01,0);
    step(1,0,0,0,0,0,0);
    chk("R4 nested take", 32'(got_vec), 32'hA);
    // R1 index 0 ignored
    step(0,0,0,1,2'd2,8'h01,8'h01);
    step(1,0,0,0,0,0,0);
    chk("R1 slot 0 never taken", 32'(got_take), 0);
    // random phase
    for (int c = 0; c < 3000; c++) begin
      logic we;
      logic [1:0] sel;
      we = ($urandom % 6) == 0;
      sel = 2'($urandom % 3);
      if (($urandom % 4) == 0) sel = 2'd2;
      step(($urandom % 3) != 0, ($urandom % 12) == 0, ($urandom % 20) == 0,
           we, sel, (sel == 2'd2) ? N'({($urandom % 5) == 0, ($urandom % 4) != 0}) : N'($urandom),
           N'($urandom) & N'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule